// File: doc/BRIEF.md
# Processor Tick Timer with Match Modes

This block is the tick timer a CPU core uses for its periodic interrupt. It holds a 32-bit up-counter and a 32-bit control word. The counter advances once for each cycle in which the tick-enable input is high. The control word holds a 28-bit period, an interrupt enable, a sticky interrupt-pending flag and a 2-bit mode field.

A match occurs on a tick when the counter's next value, taken in its low 28 bits only, equals the period. The mode field then decides what happens after the match. The counter can return to zero, stop and hold, or keep running until the 28-bit field wraps and reaches the period again. If the interrupt enable is set, the match also sets the pending flag. The interrupt output is high while the flag and the enable are both set.

Software accesses both registers through one port. A single select line picks the register for a write and also for the combinational read-back.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter reads 0x00000000, the control word reads 0x00000000 and `irq` is low.
- R2: While the mode is not "off" and the counter is not stopped, each cycle with `tick_en` high adds one to the counter. A cycle with `tick_en` low and no write leaves the counter unchanged.
- R3: With mode field 2'b00 ("off"), the counter does not advance and no match is taken, whatever `tick_en` does.
- R4: The match compares bits [27:0] of the incremented counter with the period in control bits [27:0]. Counter bits [31:28] do not take part in the comparison.
- R5: A match with the interrupt enable (control bit 29) set sets the pending flag (control bit 28). A match with the enable clear leaves the flag unchanged.
- R6: The pending flag is sticky and is cleared only by a control write with bit 28 at 0. `irq` equals pending AND enable, so clearing the enable drops `irq` and keeps the flag.
- R7: In mode 2'b01 (restart), a match loads the counter with zero instead of the matched value.
- R8: In mode 2'b10 (one-shot), a match loads the matched value and stops the counter. The counter then holds that value until software writes the counter, or writes a control word whose mode is not "off".
- R9: In mode 2'b11 (continuous), the counter takes the matched value and keeps advancing. The next match comes only after the 28-bit field wraps around.
- R10: A software write to a register in the same cycle as a match replaces that cycle's hardware update of that register. A match in that cycle still updates the register that is not written.
- R11: `rd_data` shows the counter when `reg_sel` is 0 and the control word when `reg_sel` is 1, combinationally from the stored values. The control word layout is mode [31:30], enable [29], pending [28] and period [27:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick qualifier, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 counter, 1 control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq | output | 1 | Level timer interrupt request |

## Verification
Every register result appears one clock edge after the cycle that causes it, whether that cycle is a write, a tick or a match. `rd_data` and `irq` follow the registers combinationally, with no extra cycle. The bench drives its stimulus on the falling edge and holds it through one rising edge. It reads both registers and `irq` on the next falling edge, after changing `reg_sel` and allowing a short settle delay. Each result is therefore sampled exactly one edge after the stimulus that causes it. The same-cycle collision cases are applied as a single combined cycle, so that the write and the match meet on the same edge.

// File: rtl/tick_timer_pkg.sv
// Package: shared widths and control-word layout for the tick timer.
// Assumes a 32-bit register port with the period in the low field.
package tick_timer_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 32;
    localparam int PER_W  = 28;

    typedef enum logic [1:0] {
        MD_OFF     = 2'b00,
        MD_RESTART = 2'b01,
        MD_ONESHOT = 2'b10,
        MD_CONT    = 2'b11
    } tmode_e;

    typedef struct packed {
        tmode_e           mode;
        logic             ie;
        logic             ip;
        logic [PER_W-1:0] period;
    } ctrl_word_t;
endpackage

// File: rtl/tt_match.sv
// Module: match comparator. Compares the masked next count with the period.
// Assumes PER_W <= CNT_W; counter bits above the period field are ignored.
module tt_match
    import tick_timer_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic [PER_W-1:0] period,
    output logic             eq
);
    logic [CNT_W-1:0] nxt;

    // Next count value and masked equality with the period field.
    always_comb begin
        nxt = cnt + 1'b1;
        eq  = (nxt[PER_W-1:0] == period);
    end
endmodule

// File: rtl/tt_counter.sv
// Module: count register with run/stop state and the mode-dependent match action.
// Assumes software writes take priority over the hardware update.
module tt_counter
    import tick_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_cnt,
    input  logic             wr_ctrl,
    input  tmode_e           wr_mode,
    input  logic [CNT_W-1:0] wr_data,
    input  tmode_e           mode,
    input  logic             eq,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);
    logic stopped_q;
    logic adv;

    // Advance qualifier and match event for this cycle.
    always_comb begin
        adv = tick_en && (mode != MD_OFF) && !stopped_q;
        hit = adv && eq;
    end

    // Counter register: software write, else restart or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_cnt)
            cnt_q <= wr_data;
        else if (hit && mode == MD_RESTART)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= cnt_q + 1'b1;
    end

    // Stop flag: set by a one-shot match, cleared by resuming writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stopped_q <= 1'b0;
        else if (wr_cnt || (wr_ctrl && wr_mode != MD_OFF))
            stopped_q <= 1'b0;
        else if (hit && mode == MD_ONESHOT)
            stopped_q <= 1'b1;
    end
endmodule

// File: rtl/tt_ctrl_reg.sv
// Module: control word register holding mode, enable, sticky pending and period.
// Assumes a write replaces the whole word, including the pending flag.
module tt_ctrl_reg
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              hit,
    output ctrl_word_t        ctrl_q
);
    // Control word: software write wins, else an enabled match sets pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= ctrl_word_t'(wr_data);
        else if (hit && ctrl_q.ie)
            ctrl_q.ip <= 1'b1;
    end
endmodule

// File: rtl/tick_timer.sv
// Module: tick timer top. Wires counter, comparator and control word; read mux.
// Assumes one shared select for write and read; irq is a level output.
module tick_timer
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_q;
    ctrl_word_t       ctrl_q;
    logic             eq;
    logic             hit;
    logic             wr_cnt;
    logic             wr_ctrl;
    tmode_e           wr_mode;

    // Write decode per register.
    always_comb begin
        wr_cnt  = wr_en && !reg_sel;
        wr_ctrl = wr_en && reg_sel;
        wr_mode = tmode_e'(wr_data[WORD_W-1 -: 2]);
    end

    tt_match u_match (
        .cnt    (cnt_q),
        .period (ctrl_q.period),
        .eq     (eq)
    );

    tt_counter u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_cnt  (wr_cnt),
        .wr_ctrl (wr_ctrl),
        .wr_mode (wr_mode),
        .wr_data (wr_data[CNT_W-1:0]),
        .mode    (ctrl_q.mode),
        .eq      (eq),
        .cnt_q   (cnt_q),
        .hit     (hit)
    );

    tt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .hit     (hit),
        .ctrl_q  (ctrl_q)
    );

    // Read mux and level interrupt.
    always_comb begin
        rd_data = reg_sel ? WORD_W'(ctrl_q) : WORD_W'(cnt_q);
        irq     = ctrl_q.ip && ctrl_q.ie;
    end
endmodule

// File: rtl/tick_timer_chk.sv
// Module: property checker for the tick timer, attached by bind.
// Assumes control layout mode [31:30], enable [29], pending [28].
module tick_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        wr_en,
    input logic        reg_sel,
    input logic [31:0] wr_data,
    input logic        irq,
    input logic [31:0] cnt,
    input logic [31:0] ctrl,
    input logic        hit
);
    logic cw, kw;

    // Write strobes per register.
    always_comb begin
        cw = wr_en && !reg_sel;
        kw = wr_en && reg_sel;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == 32'h0 && ctrl == 32'h0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(cnt));

    // R3
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[31:30] == 2'b00 && !wr_en) |=> $stable(cnt));

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl[29] && !kw) |=> ctrl[28]);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[28] && !kw) |=> ctrl[28]);

    // R6
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl[28] && ctrl[29]));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl[31:30] == 2'b01 && !cw) |=> (cnt == 32'h0));

    // R8
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) && $past(ctrl[31:30]) == 2'b10 && !$past(wr_en) && !wr_en)
        |=> $stable(cnt));

    // R9
    cont_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctrl[31:30] == 2'b11 && !cw) |=> (cnt == $past(cnt) + 32'h1));

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (cnt == $past(wr_data)));
endmodule

bind tick_timer tick_timer_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .reg_sel (reg_sel),
    .wr_data (wr_data),
    .irq     (irq),
    .cnt     (cnt_q),
    .ctrl    (ctrl_q),
    .hit     (hit)
);

// File: tb/tick_timer_tb_top.sv
// Bench: table-driven walk of write/tick steps, then directed reset and collision cases.
module tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tick_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // Vector: {sel, wdata, ticks, exp_cnt, exp_ctrl}
    localparam int NV = 10;
    localparam logic [104:0] VEC [NV] = '{
        {1'b1, 32'h4000_0005, 8'd3, 32'h0000_0003, 32'h4000_0005},
        {1'b0, 32'h0000_0000, 8'd5, 32'h0000_0000, 32'h4000_0005},
        {1'b1, 32'h6000_0003, 8'd2, 32'h0000_0002, 32'h6000_0003},
        {1'b1, 32'h6000_0003, 8'd1, 32'h0000_0000, 32'h7000_0003},
        {1'b1, 32'h2000_0003, 8'd4, 32'h0000_0000, 32'h2000_0003},
        {1'b1, 32'h8000_0004, 8'd6, 32'h0000_0004, 32'h8000_0004},
        {1'b0, 32'h0000_0010, 8'd3, 32'h0000_0013, 32'h8000_0004},
        {1'b0, 32'h0FFF_FFFE, 8'd0, 32'h0FFF_FFFE, 32'h8000_0004},
        {1'b1, 32'hE000_0001, 8'd3, 32'h1000_0001, 32'hF000_0001},
        {1'b1, 32'hD000_0001, 8'd2, 32'h1000_0003, 32'hD000_0001}
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R2";
            1: return "R7";
            2: return "R11";
            3: return "R5";
            4: return "R3";
            5: return "R8";
            6: return "R8";
            7: return "R11";
            8: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One write cycle, optionally with a tick in the same cycle.
    task automatic do_write(logic sel, logic [31:0] d, logic tk);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d; tick_en = tk;
        @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic do_ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    // Read both registers and irq; runs at a falling edge.
    task automatic check_all(string tag, logic [31:0] ec, logic [31:0] ek);
        reg_sel = 1'b0; #1;
        chk(tag, "count", rd_data, ec);
        reg_sel = 1'b1; #1;
        chk(tag, "ctrl", rd_data, ek);
        chk(tag, "irq", {31'h0, irq}, {31'h0, ek[28] & ek[29]});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1", 32'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 32'h0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][104], VEC[i][103:72], 1'b0);
            do_ticks(int'(VEC[i][71:64]));
            check_all(vtag(i), VEC[i][63:32], VEC[i][31:0]);
        end

        // R2: idle cycles without tick hold the count
        do_write(1'b0, 32'h0000_0007, 1'b0);
        repeat (5) @(negedge clk);
        check_all("R2", 32'h0000_0007, 32'hD000_0001);

        // R10: counter write collides with a match; pending still set
        do_write(1'b0, 32'h0, 1'b0);
        do_write(1'b1, 32'h6000_0002, 1'b0);
        do_ticks(1);
        do_write(1'b0, 32'h0000_0055, 1'b1);
        check_all("R10", 32'h0000_0055, 32'h7000_0002);

        // R10: control write collides with a restart match
        do_write(1'b0, 32'h0000_0001, 1'b0);
        do_write(1'b1, 32'h4000_0002, 1'b1);
        check_all("R10", 32'h0, 32'h4000_0002);

        // R4: upper counter bits ignored in restart mode
        do_write(1'b0, 32'hA000_0000, 1'b0);
        do_ticks(2);
        check_all("R4", 32'h0, 32'h4000_0002);

        // R1: reset in mid-run clears both registers
        do_write(1'b1, 32'h7000_0009, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1", 32'h0, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule